// File: doc/BRIEF.md
# Permuted 3D Element Index Generator

This block produces the sequence of element positions that a vector loop visits when a register is treated as a small one-, two- or three-dimensional array instead of a flat list. A 32-bit shape word gives the extent of each of three axes, a code that picks which axis steps fastest, which is next, and which is slowest, and a 3-bit base offset. Three nested counters walk the array in that order. Every position the block emits is the base offset plus the row-major linear address of the current (x, y, z) point. When the element count runs past the array size, the walk wraps, so a short array can be visited many times in one loop.

The index is sent out as a valid/ready stream. `idx_o` is meaningful while `valid_o` is high, and it advances only on a cycle where both `valid_o` and `ready_i` are high. While `ready_i` is low, the index and `valid_o` hold. A pulse on `start_i` loads a new shape and restarts the walk. If `resume_elem_i` is nonzero at that moment, the block first walks forward internally by that many elements, with `busy_o` high, so that a loop stopped by an exception can carry on from where it stopped. An output position at or beyond the register-file limit raises `overrun_o`. A reserved order code raises `bad_perm_o` and holds back the stream. A loop that needs two independently remapped operands uses two instances.

Top module: `elem_index_gen`

## Requirements
- R1: Shape word fields: x extent in bits 6..0, y extent in bits 14..8, z extent in bits 22..16, order code in bits 26..24. Offset bit 0 is shape bit 7, offset bit 1 is bit 15 and offset bit 2 is bit 23. Extent fields must fit in DIM_W bits.
- R2: Each extent field holds the axis length minus one, so a field value of 3 gives 4 elements on that axis.
- R3: The order code gives the axis sequence, fastest first, with 0=x,1=y,2=z: code 0 gives x,y,z; 1 gives x,z,y; 2 gives y,x,z; 3 gives y,z,x; 4 gives z,x,y; 5 gives z,y,x.
- R4: The index equals offset + ix + iy*X + iz*X*Y. X and Y are the real x and y lengths. The offset is zero-extended.
- R5: A shape word of all zeros gives the plain linear sequence 0,1,2,... counted modulo 2^ELEM_W.
- R6: On each accepted element the fastest axis advances. An axis at its last value returns to zero and carries into the next axis. Past the last element the walk wraps to the origin, so the sequence repeats.
- R7: `overrun_o` is high exactly when `valid_o` is high and `idx_o` >= REG_LIMIT.
- R8: A start with `resume_elem_i`=N and a legal code holds `busy_o` high for exactly N cycles with `valid_o` low. The first index then offered equals the index of element N of a walk started from zero.
- R9: A start with order code 6 or 7 sets `bad_perm_o`. The block then keeps `valid_o` and `busy_o` low until a start with a legal code, which clears the flag.
- R10: While `valid_o` is high and `ready_i` is low, `valid_o` stays high and `idx_o` is stable.
- R11: After reset, `valid_o`, `busy_o` and `bad_perm_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Load shape and restart the walk |
| shape_i | input | 32 | Shape word, sampled on start |
| resume_elem_i | input | ELEM_W | Element number to resume at, sampled on start |
| busy_o | output | 1 | Fast-forward to the resume point in progress |
| bad_perm_o | output | 1 | Reserved order code seen on the last start |
| valid_o | output | 1 | Stream valid |
| ready_i | input | 1 | Stream ready (consumer accepts `idx_o`) |
| idx_o | output | IDX_W | Remapped element index |
| overrun_o | output | 1 | Current index is at or beyond REG_LIMIT |

## Verification
The bench builds the block with DIM_W=2, ELEM_W=8 and REG_LIMIT=40. This keeps each axis at one to four elements, so all 64 extent combinations can be swept under all six order codes, each with its own offset. Each walk runs twice through the array plus one element, which covers every carry and every wrap. The limit of 40 sits inside the reachable index range, so the overrun flag is seen on both sides. An 8-bit element number lets every configuration also be resumed past its first wrap.

// File: rtl/elem_idx_pkg.sv
package elem_idx_pkg;
  localparam int NDIM = 3;
  // position of each axis within the stepping order (0 = fastest)
  typedef logic [NDIM-1:0][1:0] axis_pos_t;
endpackage

// File: rtl/perm_order_dec.sv
module perm_order_dec
  import elem_idx_pkg::*;
(
  input  logic [2:0] code_i,
  output axis_pos_t  pos_o,
  output logic       legal_o
);
  logic [NDIM-1:0][1:0] seq;  // seq[p] = axis stepped at position p

  always_comb begin
    legal_o = 1'b1;
    seq[0] = 2'd0; seq[1] = 2'd1; seq[2] = 2'd2;
    case (code_i)
      3'd0: begin seq[0] = 2'd0; seq[1] = 2'd1; seq[2] = 2'd2; end
      3'd1: begin seq[0] = 2'd0; seq[1] = 2'd2; seq[2] = 2'd1; end
      3'd2: begin seq[0] = 2'd1; seq[1] = 2'd0; seq[2] = 2'd2; end
      3'd3: begin seq[0] = 2'd1; seq[1] = 2'd2; seq[2] = 2'd0; end
      3'd4: begin seq[0] = 2'd2; seq[1] = 2'd0; seq[2] = 2'd1; end
      3'd5: begin seq[0] = 2'd2; seq[1] = 2'd1; seq[2] = 2'd0; end
      default: legal_o = 1'b0;
    endcase
    pos_o = '0;
    for (int p = 0; p < NDIM; p++) pos_o[seq[p]] = 2'(p);
  end
endmodule

// File: rtl/nest_counter.sv
module nest_counter
  import elem_idx_pkg::*;
#(
  parameter int DIM_W = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_i,
  input  logic                       step_i,
  input  logic [NDIM-1:0][DIM_W-1:0] last_i,
  input  axis_pos_t                  pos_i,
  output logic [NDIM-1:0][DIM_W-1:0] cnt_o
);
  logic [NDIM-1:0] at_last;

  always_comb
    for (int d = 0; d < NDIM; d++) at_last[d] = (cnt_o[d] == last_i[d]);

  for (genvar d = 0; d < NDIM; d++) begin : g_axis
    logic [NDIM-1:0] faster;
    logic            inc;
    always_comb begin
      for (int e = 0; e < NDIM; e++) faster[e] = (pos_i[e] < pos_i[d]);
      inc = step_i & (&(at_last | ~faster));
    end

    always_ff @(posedge clk) begin
      if (!rst_n || clr_i) cnt_o[d] <= '0;
      else if (inc)        cnt_o[d] <= at_last[d] ? '0 : cnt_o[d] + 1'b1;
    end

    // R6: counters never leave their axis range
    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_o[d] <= last_i[d]);
  end
endmodule

// File: rtl/index_linearize.sv
module index_linearize
  import elem_idx_pkg::*;
#(
  parameter int DIM_W = 7,
  parameter int IDX_W = 22
) (
  input  logic [NDIM-1:0][DIM_W-1:0] cnt_i,
  input  logic [NDIM-1:0][DIM_W-1:0] last_i,
  input  logic [2:0]                 offs_i,
  output logic [IDX_W-1:0]           idx_o
);
  logic [IDX_W-1:0] xlen, ylen, plane;

  always_comb begin
    xlen  = IDX_W'(last_i[0]) + IDX_W'(1);
    ylen  = IDX_W'(last_i[1]) + IDX_W'(1);
    plane = IDX_W'(cnt_i[1]) + ylen * IDX_W'(cnt_i[2]);
    idx_o = IDX_W'(offs_i) + IDX_W'(cnt_i[0]) + xlen * plane;
  end
endmodule

// File: rtl/elem_index_gen.sv
module elem_index_gen
  import elem_idx_pkg::*;
#(
  parameter int DIM_W     = 7,
  parameter int ELEM_W    = 16,
  parameter int REG_LIMIT = 128,
  localparam int IDX_W    = (3*DIM_W+1 > ELEM_W) ? 3*DIM_W+1 : ELEM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [31:0]       shape_i,
  input  logic [ELEM_W-1:0] resume_elem_i,
  output logic              busy_o,
  output logic              bad_perm_o,
  output logic              valid_o,
  input  logic              ready_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              overrun_o
);
  localparam logic [IDX_W:0] LIMIT_V = (IDX_W+1)'(REG_LIMIT);

  logic [NDIM-1:0][DIM_W-1:0] last_q, cnt;
  logic [2:0]        offs_q, perm_q;
  logic              linear_q, valid_q, bad_q;
  logic [ELEM_W-1:0] skip_q, elem_q;
  logic [IDX_W-1:0]  shaped_idx;
  axis_pos_t         pos;
  logic              perm_legal, start_legal, step;

  assign start_legal = (shape_i[26:24] <= 3'd5);
  assign busy_o      = (skip_q != '0);
  assign step        = (valid_q & ready_i) | busy_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q <= '0; offs_q <= '0; perm_q <= '0; linear_q <= 1'b1;
      skip_q <= '0; elem_q <= '0; valid_q <= 1'b0; bad_q <= 1'b0;
    end else if (start_i) begin
      last_q[0] <= shape_i[DIM_W-1:0];
      last_q[1] <= shape_i[8 +: DIM_W];
      last_q[2] <= shape_i[16 +: DIM_W];
      offs_q    <= {shape_i[23], shape_i[15], shape_i[7]};
      perm_q    <= shape_i[26:24];
      linear_q  <= (shape_i == 32'd0);
      skip_q    <= start_legal ? resume_elem_i : '0;
      elem_q    <= '0;
      valid_q   <= start_legal && (resume_elem_i == '0);
      bad_q     <= !start_legal;
    end else begin
      if (step) elem_q <= elem_q + 1'b1;
      if (busy_o) begin
        skip_q <= skip_q - 1'b1;
        if (skip_q == ELEM_W'(1)) valid_q <= 1'b1;
      end
    end
  end

  perm_order_dec u_dec (
    .code_i (perm_q),
    .pos_o  (pos),
    .legal_o(perm_legal)
  );

  nest_counter #(.DIM_W(DIM_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (start_i),
    .step_i(step),
    .last_i(last_q),
    .pos_i (pos),
    .cnt_o (cnt)
  );

  index_linearize #(.DIM_W(DIM_W), .IDX_W(IDX_W)) u_lin (
    .cnt_i (cnt),
    .last_i(last_q),
    .offs_i(offs_q),
    .idx_o (shaped_idx)
  );

  assign idx_o      = linear_q ? IDX_W'(elem_q) : shaped_idx;
  assign valid_o    = valid_q;
  assign bad_perm_o = bad_q;
  assign overrun_o  = valid_q && ({1'b0, idx_o} >= LIMIT_V);

  // R10: stalled stream holds its index
  p_hold_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i && !start_i |=> valid_o && $stable(idx_o));
  // R8: no index is offered while fast-forwarding
  p_busy_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_o && valid_o));
  // R9: a reserved order code keeps the stream shut
  p_bad_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bad_perm_o |-> !valid_o && !busy_o);
  // R9: anything offered was walked with a legal order
  p_valid_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> perm_legal);
  // R7: overrun only accompanies a live index
  p_ovr_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_o |-> valid_o);
  // R4: shaped index never falls below its base offset
  p_idx_floor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !linear_q |-> idx_o >= IDX_W'(offs_q));
endmodule

// File: tb/elem_index_gen_tb.sv
module elem_index_gen_tb_top;
  localparam int DIM_W = 2, ELEM_W = 8, LIMIT = 40, IDX_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, ready_i = 1'b0;
  logic [31:0] shape_i = '0;
  logic [ELEM_W-1:0] resume_elem_i = '0;
  logic busy_o, bad_perm_o, valid_o, overrun_o;
  logic [IDX_W-1:0] idx_o;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  elem_index_gen #(.DIM_W(DIM_W), .ELEM_W(ELEM_W), .REG_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .shape_i(shape_i),
    .resume_elem_i(resume_elem_i), .busy_o(busy_o), .bad_perm_o(bad_perm_o),
    .valid_o(valid_o), .ready_i(ready_i), .idx_o(idx_o), .overrun_o(overrun_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int x, int y, int z, int p, int o);
    logic [2:0] ob = 3'(o);
    return {5'b0, 3'(p), ob[2], 5'b0, 2'(z), ob[1], 5'b0, 2'(y), ob[0], 5'b0, 2'(x)};
  endfunction

  // R2 R3 R4 R5 R6: arithmetic model of element n
  function automatic int model(int x, int y, int z, int p, int o, int n);
    int len[3], c[3], s0, s1, s2, tot, m;
    if (x == 0 && y == 0 && z == 0 && p == 0 && o == 0) return n % 256;
    len[0] = x + 1; len[1] = y + 1; len[2] = z + 1;
    case (p)
      0: begin s0 = 0; s1 = 1; s2 = 2; end
      1: begin s0 = 0; s1 = 2; s2 = 1; end
      2: begin s0 = 1; s1 = 0; s2 = 2; end
      3: begin s0 = 1; s1 = 2; s2 = 0; end
      4: begin s0 = 2; s1 = 0; s2 = 1; end
      default: begin s0 = 2; s1 = 1; s2 = 0; end
    endcase
    tot = len[0] * len[1] * len[2];
    m = n % tot;
    c[s0] = m % len[s0];
    c[s1] = (m / len[s0]) % len[s1];
    c[s2] = m / (len[s0] * len[s1]);
    return o + c[0] + len[0] * c[1] + len[0] * len[1] * c[2];
  endfunction

  task automatic do_start(input logic [31:0] sh, input int elem, output int busy_cyc);
    @(negedge clk);
    shape_i = sh; resume_elem_i = ELEM_W'(elem); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    busy_cyc = 0;
    while (busy_o && busy_cyc < 1000) begin
      chk(!valid_o, "R8 valid during busy", int'(valid_o), 0);
      @(negedge clk);
      busy_cyc++;
    end
  endtask

  task automatic stream(int x, int y, int z, int p, int o, int n0, int cnt);
    for (int i = 0; i < cnt; i++) begin
      int e;
      e = model(x, y, z, p, o, n0 + i);
      chk(valid_o === 1'b1, "R10 valid", int'(valid_o), 1);
      chk(int'(idx_o) == e, "R4 R6 index", int'(idx_o), e);
      chk(overrun_o === (e >= LIMIT), "R7 overrun", int'(overrun_o), int'(e >= LIMIT));
      if ((n0 + i) % 7 == 3) begin
        ready_i = 1'b0;
        @(negedge clk);
        chk(valid_o === 1'b1 && int'(idx_o) == e, "R10 stall hold", int'(idx_o), e);
      end
      ready_i = 1'b1;
      @(negedge clk);
      ready_i = 1'b0;
    end
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int bc;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    chk(!valid_o && !busy_o && !bad_perm_o, "R11 reset state",
        int'({valid_o, busy_o, bad_perm_o}), 0);

    // R1 R2 R3 R4 R5 R6 R7: sweep every extent and order
    for (int p = 0; p < 6; p++)
      for (int z = 0; z < 4; z++)
        for (int y = 0; y < 4; y++)
          for (int x = 0; x < 4; x++) begin
            int o, tot, k;
            o = (x * 3 + y * 5 + z + p) % 8;
            tot = (x + 1) * (y + 1) * (z + 1);
            do_start(mk(x, y, z, p, o), 0, bc);
            chk(bc == 0, "R8 no busy without resume", bc, 0);
            stream(x, y, z, p, o, 0, (x|y|z|p|o) == 0 ? 20 : 2 * tot + 1);
            // R8: resume past the first wrap
            k = tot + (p * 3 + x) % tot + 1;
            do_start(mk(x, y, z, p, o), k, bc);
            chk(bc == k, "R8 busy cycles", bc, k);
            stream(x, y, z, p, o, k, 3);
          end

    // R5: all-zero shape resumed deep in the linear walk
    do_start(32'd0, 200, bc);
    chk(bc == 200, "R8 linear busy cycles", bc, 200);
    stream(0, 0, 0, 0, 0, 200, 60);

    // R9: reserved codes
    for (int c = 6; c < 8; c++) begin
      do_start(mk(1, 2, 3, c, 5), 5, bc);
      chk(bc == 0, "R9 no busy", bc, 0);
      chk(bad_perm_o === 1'b1, "R9 flag", int'(bad_perm_o), 1);
      ready_i = 1'b1;
      for (int i = 0; i < 4; i++) begin
        chk(!valid_o, "R9 valid held low", int'(valid_o), 0);
        @(negedge clk);
      end
      ready_i = 1'b0;
    end
    do_start(mk(2, 1, 1, 4, 2), 0, bc);
    chk(bad_perm_o === 1'b0, "R9 flag cleared", int'(bad_perm_o), 0);
    stream(2, 1, 1, 4, 2, 0, 13);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule